// File: doc/BRIEF.md
# Unaligned Byte-to-Word Write Packer

The block takes a frame of bytes bound for a buffer that may begin at any byte address and turns it into 32-bit word writes, each with a 4-bit byte select, for a word-addressed memory port. A frame is opened with a start pulse that carries the first byte address and the byte count. The bytes then arrive one per handshake on a valid/ready stream. Each word is offered on the write port until the memory accepts it.

Lanes are big-endian: the byte at the lowest address in a word sits in bits 31:24, and later bytes fill the lanes below. The first word is partial when the start address is not word aligned. The last word is partial when the frame ends inside a word. A frame that fits in one word gets the AND of both masks. Lanes that carry no frame byte are driven to zero. A done pulse marks the end of each frame.

The packer collects the bytes of one word, offers the write, and then collects the next word. The byte stream is stalled while a write is pending.

Top module: `byte_lane_packer`

## Requirements
- R1: Within a word write, the frame byte at the lowest address is on bits 31:24, the next on 23:16, then 15:8, then 7:0. Select bit 3 covers bits 31:24 and select bit 0 covers bits 7:0.
- R2: When the frame is longer than the head room of its first word, the first write has select 1111, 0111, 0011 or 0001 for a start address whose two low bits are 0, 1, 2 or 3.
- R3: When the frame ends inside a word, the final write has select 1110, 1100 or 1000 for 3, 2 or 1 bytes left in that word.
- R4: Every word between the first and the last has select 1111. The write address is the byte address with its two low bits cleared, and it rises by 4 per write. A frame of N bytes at offset f issues ceil((f+N)/4) writes.
- R5: A data lane whose select bit is 0 reads as zero.
- R6: A frame that starts and ends within one word issues a single write whose select is the AND of the head mask (from the offset) and the tail mask (from the end position).
- R7: A frame of length zero produces no write, and `done_o` pulses in the cycle after the start pulse.
- R8: `done_o` is high for exactly the one cycle after the final write of a frame is accepted (`wr_stb_o` and `wr_ready_i` both high at a clock edge), and at no other time.
- R9: While `wr_stb_o` is high and `wr_ready_i` is low, the strobe, address, data and select hold their values into the next cycle.
- R10: `byte_ready_o` is low whenever `wr_stb_o` is high. A start pulse that arrives while a frame is in progress is ignored.
- R11: After reset, `wr_stb_o`, `byte_ready_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a frame; taken only when idle |
| start_addr_i | input | AW | Byte address of the first frame byte |
| length_i | input | LW | Byte count of the frame |
| byte_valid_i | input | 1 | Stream byte present |
| byte_data_i | input | 8 | Stream byte |
| byte_ready_o | output | 1 | Packer takes a byte this cycle |
| wr_addr_o | output | AW | Byte address of the word, low two bits zero |
| wr_data_o | output | 32 | Word data, big-endian lanes |
| wr_sel_o | output | 4 | Byte select, bit 3 = bits 31:24 |
| wr_stb_o | output | 1 | Write request |
| wr_ready_i | input | 1 | Memory accepts the write this cycle |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
A byte offered while `byte_ready_o` is high is taken at the next edge. The write that holds the last byte of a word is on the port from the edge that took that byte, so the bench compares address, select and data at the falling edge of every cycle in which the strobe and the ready are both high. `done_o` is due one cycle after the accepting edge, or one cycle after a zero-length start. The bench computes that cycle from the strobe and ready it saw at the previous falling edge and checks `done_o` in every cycle where either the pulse is due or it appears. A write that stalls is compared in the following cycle against the values recorded during the stall.

// File: rtl/pk_pkg.sv
package pk_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } pk_state_e;
endpackage

// File: rtl/pk_mask_gen.sv
// Byte select for one word: lanes from first_lane_i up to the last byte left.
module pk_mask_gen #(
  parameter int unsigned LW = 12
) (
  input  logic [1:0]    first_lane_i,
  input  logic [LW-1:0] remain_i,
  output logic [3:0]    sel_o
);
  localparam logic [LW-1:0] FOUR = LW'(4);

  logic [2:0] cnt;
  logic [3:0] end_pos;
  logic [3:0] head;

  assign cnt     = (remain_i >= FOUR) ? 3'd4 : remain_i[2:0];
  assign end_pos = {2'b00, first_lane_i} + {1'b0, cnt};
  assign head    = 4'hF >> first_lane_i;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign sel_o[3-g] = head[3-g] & (4'(g) < end_pos);
  end
endmodule

// File: rtl/pk_lane_buf.sv
// Word assembly register, one byte lane per generate slice.
module pk_lane_buf (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        wr_i,
  input  logic [1:0]  lane_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] word_o
);
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (clr_i)                        q <= '0;
      else if (wr_i && (lane_i == 2'(g)))    q <= byte_i;
    end
    assign word_o[31-8*g -: 8] = q;
  end
endmodule

// File: rtl/pk_ctrl.sv
module pk_ctrl
  import pk_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [LW-1:0] length_i,
  input  logic          byte_valid_i,
  output logic          byte_ready_o,
  input  logic          wr_ready_i,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [3:0]    wr_sel_o,
  output logic          done_o,
  // mask generator
  output logic [1:0]    mask_first_o,
  output logic [LW-1:0] mask_remain_o,
  input  logic [3:0]    mask_sel_i,
  // lane buffer
  output logic          buf_clr_o,
  output logic          buf_wr_o,
  output logic [1:0]    buf_lane_o
);
  localparam int unsigned WW = AW - 2;
  localparam logic [WW-1:0] W_ONE = WW'(1);
  localparam logic [LW-1:0] L_ONE = LW'(1);

  pk_state_e     state_q;
  logic [1:0]    lane_q;
  logic [LW-1:0] rem_q;
  logic [WW-1:0] waddr_q;
  logic [3:0]    sel_q;
  logic          done_q;

  logic take_start, open_frame, byte_acc, word_full, wr_acc, frame_end;

  assign take_start = (state_q == ST_IDLE) && start_i;
  assign open_frame = take_start && (length_i != '0);
  assign byte_acc   = (state_q == ST_FILL) && byte_valid_i;
  assign word_full  = (lane_q == 2'd3) || (rem_q == L_ONE);
  assign wr_acc     = (state_q == ST_WRITE) && wr_ready_i;
  assign frame_end  = wr_acc && (rem_q == '0);

  // Mask for the next word: from the start inputs when idle, else from lane 0.
  assign mask_first_o  = (state_q == ST_IDLE) ? start_addr_i[1:0] : 2'd0;
  assign mask_remain_o = (state_q == ST_IDLE) ? length_i : rem_q;

  assign buf_clr_o  = open_frame || (wr_acc && !frame_end);
  assign buf_wr_o   = byte_acc;
  assign buf_lane_o = lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
      rem_q   <= '0;
      waddr_q <= '0;
      sel_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take_start) begin
            waddr_q <= start_addr_i[AW-1:2];
            lane_q  <= start_addr_i[1:0];
            rem_q   <= length_i;
            if (length_i == '0) begin
              done_q <= 1'b1;
            end else begin
              sel_q   <= mask_sel_i;
              state_q <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (byte_acc) begin
            rem_q <= rem_q - L_ONE;
            if (word_full) state_q <= ST_WRITE;
            else           lane_q  <= lane_q + 2'd1;
          end
        end
        ST_WRITE: begin
          if (wr_acc) begin
            if (rem_q == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_FILL;
              lane_q  <= 2'd0;
              waddr_q <= waddr_q + W_ONE;
              sel_q   <= mask_sel_i;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign byte_ready_o = (state_q == ST_FILL);
  assign wr_stb_o     = (state_q == ST_WRITE);
  assign wr_addr_o    = {waddr_q, 2'b00};
  assign wr_sel_o     = sel_q;
  assign done_o       = done_q;
endmodule

// File: rtl/byte_lane_packer.sv
module byte_lane_packer #(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [LW-1:0] length_i,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_data_i,
  output logic          byte_ready_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [31:0]   wr_data_o,
  output logic [3:0]    wr_sel_o,
  output logic          wr_stb_o,
  input  logic          wr_ready_i,
  output logic          done_o
);
  logic [1:0]    mask_first;
  logic [LW-1:0] mask_remain;
  logic [3:0]    mask_sel;
  logic          buf_clr, buf_wr;
  logic [1:0]    buf_lane;

  pk_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .start_addr_i  (start_addr_i),
    .length_i      (length_i),
    .byte_valid_i  (byte_valid_i),
    .byte_ready_o  (byte_ready_o),
    .wr_ready_i    (wr_ready_i),
    .wr_stb_o      (wr_stb_o),
    .wr_addr_o     (wr_addr_o),
    .wr_sel_o      (wr_sel_o),
    .done_o        (done_o),
    .mask_first_o  (mask_first),
    .mask_remain_o (mask_remain),
    .mask_sel_i    (mask_sel),
    .buf_clr_o     (buf_clr),
    .buf_wr_o      (buf_wr),
    .buf_lane_o    (buf_lane)
  );

  pk_mask_gen #(.LW(LW)) u_mask (
    .first_lane_i (mask_first),
    .remain_i     (mask_remain),
    .sel_o        (mask_sel)
  );

  pk_lane_buf u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (buf_clr),
    .wr_i   (buf_wr),
    .lane_i (buf_lane),
    .byte_i (byte_data_i),
    .word_o (wr_data_o)
  );
endmodule

// File: rtl/pk_checker.sv
module pk_checker #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          byte_ready_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [31:0]   wr_data_o,
  input logic [3:0]    wr_sel_o,
  input logic          wr_stb_o,
  input logic          wr_ready_i,
  input logic          done_o
);
  logic [31:0] dead_lanes;
  assign dead_lanes = {{8{~wr_sel_o[3]}}, {8{~wr_sel_o[2]}},
                       {8{~wr_sel_o[1]}}, {8{~wr_sel_o[0]}}};

  AST_STB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o && !wr_ready_i |=> wr_stb_o && $stable(wr_addr_o) &&
    $stable(wr_data_o) && $stable(wr_sel_o)); // R9

  AST_NO_FEED_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> !byte_ready_o); // R10

  AST_DEAD_LANES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (wr_data_o & dead_lanes) == 32'h0); // R5

  AST_SEL_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> wr_sel_o != 4'h0); // R7

  AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> wr_addr_o[1:0] == 2'b00); // R4

  AST_SEL_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> !(wr_sel_o inside {4'h5, 4'h9, 4'hA, 4'hB, 4'hD})); // R6

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && $past(wr_stb_o) |-> $past(wr_ready_i)); // R8
endmodule

bind byte_lane_packer pk_checker #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_ready_o (byte_ready_o),
  .wr_addr_o    (wr_addr_o),
  .wr_data_o    (wr_data_o),
  .wr_sel_o     (wr_sel_o),
  .wr_stb_o     (wr_stb_o),
  .wr_ready_i   (wr_ready_i),
  .done_o       (done_o)
);

// File: tb/sim_byte_lane_packer.sv
`timescale 1ns/1ps
module sim_byte_lane_packer;
  localparam int AW = 16;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] length = '0;
  logic          bvalid = 1'b0;
  logic [7:0]    bdata = '0;
  logic          bready;
  logic [AW-1:0] waddr;
  logic [31:0]   wdata;
  logic [3:0]    wsel;
  logic          wstb;
  logic          wready = 1'b1;
  logic          done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int stall_mode = 0;

  // frame under test
  int  fr_st = 0, fr_len = 0, exp_w = 0, nwr = 0, done_cnt = 0;
  bit  busy_tb = 1'b0;
  bit  pend_done = 1'b0;
  bit  hold_chk = 1'b0;
  logic [AW-1:0] h_addr;
  logic [31:0]   h_data;
  logic [3:0]    h_sel;

  always #5 clk = ~clk;

  byte_lane_packer #(.AW(AW), .LW(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr),
    .length_i(length), .byte_valid_i(bvalid), .byte_data_i(bdata),
    .byte_ready_o(bready), .wr_addr_o(waddr), .wr_data_o(wdata),
    .wr_sel_o(wsel), .wr_stb_o(wstb), .wr_ready_i(wready), .done_o(done)
  );

  function automatic logic [7:0] pat(int st, int i);
    return 8'((st * 7 + i * 13 + 5) & 255);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // memory-side ready pattern
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2;
    wready = (stall_mode == 0) ? 1'b1 : ((cyc % (stall_mode + 1)) != 0);
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      finish_run();
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      // R9 stalled write must hold
      if (hold_chk) begin
        chk(wstb && waddr == h_addr && wdata == h_data && wsel == h_sel,
            "R9", "stalled write held", {wstb, waddr, wsel, wdata}, {1'b1, h_addr, h_sel, h_data});
      end
      hold_chk = wstb && !wready;
      h_addr = waddr; h_data = wdata; h_sel = wsel;

      // R8 / R7 done timing
      if (pend_done || done)
        chk(done == pend_done, pend_done && fr_len == 0 ? "R7" : "R8",
            "done timing", done, pend_done);
      if (done) done_cnt++;

      if (wstb) chk(!bready, "R10", "byte_ready during write", bready, 0);

      pend_done = start && length == '0 && !busy_tb;
      if (wstb && wready) begin
        int w4;
        logic [3:0]  es;
        logic [31:0] ed;
        bit first, last;
        string tag;
        w4 = exp_w;
        first = (w4 == (fr_st & ~3));
        last  = (w4 == ((fr_st + fr_len - 1) & ~3));
        for (int k = 0; k < 4; k++) begin
          int b;
          b = w4 + k;
          if (b >= fr_st && b < fr_st + fr_len) begin
            es[3-k] = 1'b1;
            ed[31-8*k -: 8] = pat(fr_st, b - fr_st);
          end else begin
            es[3-k] = 1'b0;
            ed[31-8*k -: 8] = 8'h00;
          end
        end
        tag = (first && last) ? "R6" : first ? "R2" : last ? "R3" : "R4";
        chk(waddr == AW'(w4), "R4", "word address", waddr, w4);
        chk(wsel == es, tag, "byte select", wsel, es);
        chk(wdata == ed, (wsel == es && es != 4'hF) ? "R5" : "R1", "word data", wdata, ed);
        exp_w = exp_w + 4;
        nwr++;
        pend_done = last;
      end
    end
  end

  task automatic run_frame(int st, int len, bit stray);
    int n_exp, d0, t;
    @(posedge clk); #2;
    fr_st = st; fr_len = len; exp_w = st & ~3; nwr = 0;
    d0 = done_cnt;
    start = 1'b1; start_addr = AW'(st); length = LW'(len);
    @(posedge clk); #2;
    start = 1'b0;
    busy_tb = (len != 0);
    for (int i = 0; i < len; i++) begin
      bit hs;
      if (i % 3 == 2 && stall_mode == 1) begin
        bvalid = 1'b0; @(posedge clk); #2;
      end
      if (stray && i == 2) begin
        // R10: start while busy must be ignored
        start = 1'b1; start_addr = AW'(st + 1); length = LW'(5);
      end
      bvalid = 1'b1; bdata = pat(st, i);
      do begin
        hs = bready;
        @(posedge clk); #2;
        start = 1'b0;
      end while (!hs);
    end
    bvalid = 1'b0;
    t = 0;
    while (done_cnt == d0 && t < 500) begin @(negedge clk); t++; end
    if (done_cnt == d0) chk(0, "R8", "done never arrived", 0, 1);
    n_exp = (len == 0) ? 0 : ((st % 4) + len + 3) / 4;
    chk(nwr == n_exp, len == 0 ? "R7" : "R4", "write count", nwr, n_exp);
    busy_tb = 1'b0;
  endtask

  initial begin
    int lens[12] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 17, 40};
    repeat (3) @(posedge clk);
    #2;
    chk(!wstb && !bready && !done, "R11", "outputs in reset", {wstb, bready, done}, 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk(!wstb && !bready && !done, "R11", "outputs after reset", {wstb, bready, done}, 0);

    for (int s = 0; s < 3; s++) begin
      stall_mode = s;
      for (int off = 0; off < 4; off++)
        foreach (lens[j])
          run_frame(256 + 64 * lens[j] + 1024 * s + off, lens[j], 1'b0);
    end
    stall_mode = 0;
    run_frame(4096 + 1, 11, 1'b1);
    stall_mode = 2;
    run_frame(8192 + 3, 9, 1'b1);
    run_frame(8192 + 2, 0, 1'b0);
    finish_run();
  end
endmodule